// File: doc/BRIEF.md
# Sequential-Access Constraint Register File

This block holds a set of 16-bit constraint words that downstream track-building logic reads all at once over a wide parallel bus. A host reaches the words one at a time through an internal index pointer. One command clears the pointer. Another presets it to a chosen index. A data command then reads or writes the word under the pointer and advances the pointer, so a whole table can be streamed in or out after a single clear. A single word can also be patched with one preset followed by one write.

Data commands only take effect while a protection input is high. Some indices are reserved slots. They take writes without complaint, but they always present all ones. Every real slot comes up at its own reset value. Two slots hold signed offsets in sign-magnitude form, and the block also presents these as two's-complement values.

Top module: `cstr_regfile`

## Requirements
- R1: After reset, the pointer is 0, `rd_valid` and `rd_data` are 0, and the slots hold their defaults: slot 2 = 7, slots 14 to 18 = 127, slot 39 = 60, slot 40 = 200, slot 41 = 0 and slot 42 = 2048.
- R2: `cmd_op` = 1 clears the pointer to 0, whatever the protection input is.
- R3: `cmd_op` = 2 loads `cmd_wdata` into the pointer when the value is below 43, whatever the protection input is. A value of 43 or more leaves the pointer unchanged.
- R4: `cmd_op` = 3 with `prot_en` high stores `cmd_wdata` in the slot under the pointer. The slot's lane of `param_bus` (bits 16*i+15 down to 16*i) shows the new value one cycle later, and the pointer advances by one.
- R5: `cmd_op` = 4 with `prot_en` high makes `rd_valid` high for one cycle on the next cycle, with `rd_data` holding the slot under the pointer. The pointer then advances by one.
- R6: A data access at index 42 wraps the pointer to 0.
- R7: A write while `prot_en` is low changes no slot and does not move the pointer.
- R8: A read while `prot_en` is low still pulses `rd_valid`, but `rd_data` is 0 and the pointer does not move.
- R9: Slots 0, 1, 19, 31, 37 and 38 are reserved. A write to one of them advances the pointer but stores nothing, and both reads and `param_bus` show 0xFFFF for these slots.
- R10: Slots 41 and 42 are read as sign-magnitude, with bit 12 as the sign and bits 11:0 as the magnitude. `ofs_a` (from slot 41) and `ofs_b` (from slot 42) present them as 13-bit two's complement, and negative zero shows as 0.
- R11: `cmd_op` values 0, 5, 6 and 7 change neither the pointer nor any slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prot_en | input | 1 | Protection mode; enables data commands |
| cmd_op | input | 3 | Command: 0 idle, 1 clear pointer, 2 load pointer, 3 write, 4 read |
| cmd_wdata | input | 16 | Write data, or the index for a load |
| rd_valid | output | 1 | Pulses one cycle after a read command |
| rd_data | output | 16 | Read result |
| param_bus | output | 688 | All 43 slots, slot i in bits 16*i+15 down to 16*i |
| ofs_a | output | 13 | Slot 41 as a signed two's-complement value |
| ofs_b | output | 13 | Slot 42 as a signed two's-complement value |

## Verification
A full streamed write of distinct values followed by a full streamed read shows whether the pointer steps exactly once per access and whether the reserved slots ignore data. A preset to a single index, a rejected out-of-range preset, and reads across index 42 separate preset, hold and wrap behaviour. Commands issued with protection low, followed by a protected read of the same slot, show that neither the slot nor the pointer was touched. Sign-magnitude words that are positive, negative and negative zero tell a correct conversion apart from a plain sign extension.

// File: rtl/cstr_rf_pkg.sv
package cstr_rf_pkg;

    parameter int unsigned NUM_ENTRIES = 43;
    parameter int unsigned DATA_W      = 16;
    parameter int unsigned ADDR_W      = $clog2(NUM_ENTRIES);
    parameter int unsigned SM_SIGN_BIT = 12;
    parameter int unsigned OFS_W       = SM_SIGN_BIT + 1;
    parameter int unsigned IDX_OFS_A   = 41;
    parameter int unsigned IDX_OFS_B   = 42;

    localparam logic [2:0] OP_IDLE      = 3'd0;
    localparam logic [2:0] OP_ADDR_CLR  = 3'd1;
    localparam logic [2:0] OP_ADDR_LOAD = 3'd2;
    localparam logic [2:0] OP_WRITE     = 3'd3;
    localparam logic [2:0] OP_READ      = 3'd4;

    typedef struct packed {
        logic              clr;
        logic              load;
        logic              wr;
        logic              rd;
        logic [DATA_W-1:0] data;
    } host_req_t;

    // Reserved slots: accept writes, always present all ones.
    function automatic logic is_reserved(int unsigned idx);
        case (idx)
            0, 1, 19, 31, 37, 38: return 1'b1;
            default:              return 1'b0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] default_of(int unsigned idx);
        if (is_reserved(idx)) return '1;
        case (idx)
            2:                   return DATA_W'(7);
            3, 4:                return DATA_W'(14);
            5, 6, 9:             return DATA_W'(21);
            8:                   return DATA_W'(1);
            10:                  return DATA_W'(8);
            11, 12:              return DATA_W'(19);
            13:                  return DATA_W'(30);
            14, 15, 16, 17, 18:  return DATA_W'(127);
            20:                  return DATA_W'(24);
            21:                  return DATA_W'(127);
            22:                  return DATA_W'(14);
            23, 24:              return DATA_W'(25);
            25:                  return DATA_W'(36);
            26, 27, 28, 29, 30:  return DATA_W'(6);
            32:                  return DATA_W'(6);
            33, 34, 35, 36:      return DATA_W'(64);
            39:                  return DATA_W'(60);
            40:                  return DATA_W'(200);
            42:                  return DATA_W'(2048);
            default:             return '0;
        endcase
    endfunction

endpackage

// File: rtl/cstr_addr_ctr.sv
module cstr_addr_ctr #(
    parameter int unsigned NUM_ENTRIES = 43,
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned ADDR_W      = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              load,
    input  logic [DATA_W-1:0] load_idx,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_ENTRIES - 1);

    logic load_ok;
    assign load_ok = load && (32'(load_idx) < NUM_ENTRIES);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (clr) begin
            ptr <= '0;
        end else if (load_ok) begin
            ptr <= load_idx[ADDR_W-1:0];
        end else if (step) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/cstr_store.sv
module cstr_store
    import cstr_rf_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 43,
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned ADDR_W      = $clog2(NUM_ENTRIES)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_idx,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [NUM_ENTRIES*DATA_W-1:0] slots
);
    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_slot
        if (is_reserved(i)) begin : g_rsv
            assign slots[i*DATA_W +: DATA_W] = '1;
        end else begin : g_reg
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= default_of(i);
                end else if (wr_en && (wr_idx == ADDR_W'(i))) begin
                    q <= wr_data;
                end
            end
            assign slots[i*DATA_W +: DATA_W] = q;
        end
    end
endmodule

// File: rtl/cstr_sm2tc.sv
module cstr_sm2tc #(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned SIGN_BIT = 12,
    parameter int unsigned OUT_W    = SIGN_BIT + 1
) (
    input  logic [DATA_W-1:0]       sm_in,
    output logic signed [OUT_W-1:0] tc_out
);
    logic signed [OUT_W-1:0] mag;
    assign mag    = {1'b0, sm_in[SIGN_BIT-1:0]};
    assign tc_out = sm_in[SIGN_BIT] ? -mag : mag;
endmodule

// File: rtl/cstr_regfile.sv
module cstr_regfile
    import cstr_rf_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               prot_en,
    input  logic [2:0]                         cmd_op,
    input  logic [DATA_W-1:0]                  cmd_wdata,
    output logic                               rd_valid,
    output logic [DATA_W-1:0]                  rd_data,
    output logic [NUM_ENTRIES*DATA_W-1:0]      param_bus,
    output logic signed [OFS_W-1:0]            ofs_a,
    output logic signed [OFS_W-1:0]            ofs_b
);
    host_req_t         req;
    logic [ADDR_W-1:0] addr_ptr;
    logic              step;
    logic              wr_en;
    logic [DATA_W-1:0] sel_word;

    always_comb begin
        req      = '0;
        req.data = cmd_wdata;
        case (cmd_op)
            OP_ADDR_CLR:  req.clr  = 1'b1;
            OP_ADDR_LOAD: req.load = 1'b1;
            OP_WRITE:     req.wr   = 1'b1;
            OP_READ:      req.rd   = 1'b1;
            default:      ;
        endcase
    end

    assign step  = (req.wr || req.rd) && prot_en;
    assign wr_en = req.wr && prot_en;

    cstr_addr_ctr #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .DATA_W      (DATA_W),
        .ADDR_W      (ADDR_W)
    ) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .clr      (req.clr),
        .load     (req.load),
        .load_idx (req.data),
        .step     (step),
        .ptr      (addr_ptr)
    );

    cstr_store #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .DATA_W      (DATA_W),
        .ADDR_W      (ADDR_W)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (addr_ptr),
        .wr_data (req.data),
        .slots   (param_bus)
    );

    assign sel_word = param_bus[int'(addr_ptr)*DATA_W +: DATA_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= req.rd;
            if (req.rd) begin
                rd_data <= prot_en ? sel_word : '0;
            end
        end
    end

    cstr_sm2tc #(.DATA_W(DATA_W), .SIGN_BIT(SM_SIGN_BIT), .OUT_W(OFS_W)) u_ofs_a (
        .sm_in  (param_bus[IDX_OFS_A*DATA_W +: DATA_W]),
        .tc_out (ofs_a)
    );

    cstr_sm2tc #(.DATA_W(DATA_W), .SIGN_BIT(SM_SIGN_BIT), .OUT_W(OFS_W)) u_ofs_b (
        .sm_in  (param_bus[IDX_OFS_B*DATA_W +: DATA_W]),
        .tc_out (ofs_b)
    );
endmodule

// File: rtl/cstr_regfile_chk.sv
module cstr_regfile_chk
    import cstr_rf_pkg::*;
(
    input logic                          clk,
    input logic                          rst,
    input logic                          prot_en,
    input logic [2:0]                    cmd_op,
    input logic [ADDR_W-1:0]             ptr,
    input logic                          rd_valid,
    input logic [DATA_W-1:0]             rd_data,
    input logic [NUM_ENTRIES*DATA_W-1:0] param_bus
);
    p_ptr_in_range_r6: assert property (@(posedge clk) disable iff (rst)
        32'(ptr) < NUM_ENTRIES);

    p_clear_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == OP_ADDR_CLR) |=> (ptr == '0));

    p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        ((cmd_op == OP_WRITE || cmd_op == OP_READ) && prot_en &&
         32'(ptr) == NUM_ENTRIES - 1) |=> (ptr == '0));

    p_read_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == OP_READ) |=> rd_valid);

    p_unprot_read_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == OP_READ && !prot_en) |=> (rd_data == '0 && $stable(ptr)));

    p_unprot_write_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == OP_WRITE && !prot_en) |=> ($stable(param_bus) && $stable(ptr)));

    p_reserved_ones_r9: assert property (@(posedge clk) disable iff (rst)
        param_bus[19*DATA_W +: DATA_W] == '1 && param_bus[0 +: DATA_W] == '1);

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == OP_IDLE || cmd_op > OP_READ) |=> ($stable(ptr) && $stable(param_bus)));
endmodule

bind cstr_regfile cstr_regfile_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .prot_en   (prot_en),
    .cmd_op    (cmd_op),
    .ptr       (addr_ptr),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .param_bus (param_bus)
);

// File: tb/cstr_regfile_test.sv
`timescale 1ns/1ps
module cstr_regfile_test;
    localparam int N = 43;
    localparam int W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              prot_en = 1'b1;
    logic [2:0]        cmd_op = 3'd0;
    logic [W-1:0]      cmd_wdata = '0;
    logic              rd_valid;
    logic [W-1:0]      rd_data;
    logic [N*W-1:0]    param_bus;
    logic signed [12:0] ofs_a, ofs_b;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] mdl [N];

    always #4 clk = ~clk;

    cstr_regfile uut (
        .clk(clk), .rst(rst), .prot_en(prot_en), .cmd_op(cmd_op),
        .cmd_wdata(cmd_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .param_bus(param_bus), .ofs_a(ofs_a), .ofs_b(ofs_b)
    );

    function automatic bit rsv(int i);
        return (i == 0 || i == 1 || i == 19 || i == 31 || i == 37 || i == 38);
    endfunction

    function automatic logic [W-1:0] expect_word(int i);
        return rsv(i) ? 16'hFFFF : mdl[i];
    endfunction

    function automatic logic [W-1:0] lane(int i);
        return param_bus[i*W +: W];
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0d (0x%h) exp=%0d (0x%h)", req, act, act, exp, exp);
        end
    endtask

    // Drive one command for one edge; returns at the following negedge.
    task automatic cmd(logic [2:0] op, logic [W-1:0] d);
        @(negedge clk);
        cmd_op = op;
        cmd_wdata = d;
        @(negedge clk);
        cmd_op = 3'd0;
        cmd_wdata = '0;
    endtask

    task automatic host_write(logic [W-1:0] d);
        cmd(3'd3, d);
    endtask

    task automatic host_read(string req, int exp);
        cmd(3'd4, '0);
        chk({req, " rd_valid"}, int'(rd_valid), 1);
        chk({req, " rd_data"}, int'(rd_data), exp);
    endtask

    task automatic t_reset;
        chk("R1 rd_valid", int'(rd_valid), 0);
        chk("R1 rd_data", int'(rd_data), 0);
        chk("R1 slot2", int'(lane(2)), 7);
        for (int i = 14; i <= 18; i++) chk("R1 slot14-18", int'(lane(i)), 127);
        chk("R1 slot39", int'(lane(39)), 60);
        chk("R1 slot40", int'(lane(40)), 200);
        chk("R1 slot41", int'(lane(41)), 0);
        chk("R1 slot42", int'(lane(42)), 2048);
        chk("R9 reset reserved", int'(lane(31)), 16'hFFFF);
        host_read("R1 pointer starts at 0", 16'hFFFF);
        host_read("R1 pointer steps to 1", 16'hFFFF);
        host_read("R1 slot2 via read", 7);
    endtask

    task automatic t_stream;
        cmd(3'd1, '0);
        for (int i = 0; i < N; i++) begin
            logic [W-1:0] v;
            v = 16'h0100 + W'(i * 7);
            host_write(v);
            if (!rsv(i)) mdl[i] = v;
            chk("R4/R9 lane after write", int'(lane(i)), int'(expect_word(i)));
        end
        cmd(3'd1, '0);
        for (int i = 0; i < N; i++) host_read("R2/R5/R9 stream read", int'(expect_word(i)));
        @(negedge clk);
        chk("R5 rd_valid one cycle", int'(rd_valid), 0);
    endtask

    task automatic t_load;
        cmd(3'd2, 16'd7);
        host_write(16'hABCD);
        mdl[7] = 16'hABCD;
        chk("R3 preset write lane7", int'(lane(7)), 16'hABCD);
        chk("R3 neighbour lane6", int'(lane(6)), int'(mdl[6]));
        chk("R3 neighbour lane8", int'(lane(8)), int'(mdl[8]));
        cmd(3'd2, 16'd50);
        host_read("R3 out-of-range load ignored", int'(mdl[8]));
    endtask

    task automatic t_wrap;
        cmd(3'd2, 16'd42);
        host_read("R6 slot42", int'(mdl[42]));
        host_read("R6 wrapped to 0", 16'hFFFF);
        host_read("R6 slot1", 16'hFFFF);
        host_read("R6 slot2", int'(mdl[2]));
    endtask

    task automatic t_protect;
        prot_en = 1'b0;
        cmd(3'd2, 16'd5);
        host_write(16'h1234);
        chk("R7 unprotected write lane5", int'(lane(5)), int'(mdl[5]));
        host_read("R8 unprotected read zero", 0);
        prot_en = 1'b1;
        host_read("R7/R8 pointer not moved", int'(mdl[5]));
    endtask

    task automatic t_signmag;
        cmd(3'd2, 16'd41);
        host_write(16'h1005);
        host_write(16'h0FFF);
        mdl[41] = 16'h1005;
        mdl[42] = 16'h0FFF;
        chk("R10 ofs_a negative", int'(ofs_a), -5);
        chk("R10 ofs_b positive max", int'(ofs_b), 4095);
        cmd(3'd2, 16'd41);
        host_write(16'h1000);
        mdl[41] = 16'h1000;
        chk("R10 ofs_a negative zero", int'(ofs_a), 0);
        host_write(16'h1FFF);
        mdl[42] = 16'h1FFF;
        chk("R10 ofs_b negative max", int'(ofs_b), -4095);
    endtask

    task automatic t_idle;
        cmd(3'd2, 16'd10);
        cmd(3'd0, 16'd3);
        cmd(3'd5, 16'd3);
        cmd(3'd6, 16'd3);
        cmd(3'd7, 16'd3);
        chk("R11 no read pulse", int'(rd_valid), 0);
        chk("R11 lane10 unchanged", int'(lane(10)), int'(mdl[10]));
        host_read("R11 pointer held", int'(mdl[10]));
    endtask

    initial begin
        for (int i = 0; i < N; i++) mdl[i] = '0;
        mdl[2] = 7; mdl[39] = 60; mdl[40] = 200; mdl[42] = 2048;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_stream;
        t_load;
        t_wrap;
        t_protect;
        t_signmag;
        t_idle;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule